// File: doc/BRIEF.md
# Accumulator Instruction Execution Core

This block runs programs written for a compact accumulator instruction set. Every instruction is two 32-bit words long: an opcode word, then an argument word. The core fetches both words over a single word-addressed memory port. It optionally reads one operand and then executes the instruction against a 32-bit accumulator. Local variables sit at a fixed frame base (`FP_INIT`). A stack pointer that starts at `SP_INIT` grows upward on every push.

The memory port is combinational on the read side: `memRdData` must show the word at `memAddr` in the same cycle. Writes take effect on the clock edge while `memWrEn` is high. Each supported instruction takes four cycles: opcode fetch, argument fetch, operand read, execute.

Opcodes the core does not carry out stop it with `badOp`. This includes procedure call and return, the system call, the table-switch and the indexed vector forms. A zero divisor stops it with `divZero`. Either way `halted` stays high until reset. A program therefore ends by placing an unsupported opcode (for example 0) after its last instruction.

Top module: `acc_core`

## Requirements
- R1: While reset is held, `halted`, `badOp`, `divZero` and `memWrEn` are 0 and `memAddr` is 0. The first opcode is fetched from word 0.
- R2: The opcode word is at pc and the argument word is at pc+1. After a non-jump instruction pc advances by 2. A supported instruction takes exactly four clock cycles. The core writes at most once per instruction, in its last cycle. An unsupported opcode raises `halted` two cycles after its fetch starts.
- R3: Opcodes 1 to 16 combine AC with the operand V = M[fp+arg] and put the result in AC. The map is: 1 add, 2 subtract, 3 multiply, 4 signed divide, 5 AND, 6 OR, 7 XOR, 8 signed remainder, 9 equal, 10 not equal, 11 less, 12 less-or-equal, 13 greater, 14 greater-or-equal, 15 shift left, 16 logical shift right. Comparisons are signed and give 1 or 0. Shifts use the low 5 bits of V. Division truncates toward zero.
- R4: The immediate opcodes apply the same operation with the argument word itself in place of V. They are 17 add, 18 subtract, 19 AND, 20 OR, 21 equal, 22 less, 23 less-or-equal, 24 shift left and 25 shift right.
- R5: The data opcodes are 28 (AC = arg), 34 (AC = M[arg]), 35 (M[arg] = AC), 32 (AC = M[fp+arg]) and 33 (M[fp+arg] = AC).
- R6: Opcode 41 always jumps to the word address in the argument. Opcode 42 jumps there only when AC is nonzero. Opcode 43 jumps there only when AC is zero.
- R7: Opcode 49 splits its argument into a target in bits 31:8 and a local offset in bits 7:0. It jumps to the target when signed AC <= M[fp+offset].
- R8: Opcode 26 adds one to M[fp+arg] and opcode 27 subtracts one from it. Each writes the new value back and also leaves it in AC.
- R9: Opcode 31 first increments sp, then writes to M[sp]. It writes AC when the argument is 0 and M[fp+arg] otherwise.
- R10: Opcode 30 sets AC to 1 when AC is 0, and to 0 otherwise.
- R11: A zero divisor for opcode 4 or 8 sets `divZero` and `halted`. AC is left unchanged and nothing is written. `badOp` stays 0.
- R12: Opcodes 0, 29, 36-40, 44-48, 50 and any value above 50 set `badOp` and `halted` without writing memory. Once halted, the core makes no further write until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | ADDR_W | Word address for read and write |
| memRdData | input | 32 | Word at memAddr, same cycle |
| memWrEn | output | 1 | Write strobe |
| memWrData | output | 32 | Write data |
| halted | output | 1 | Core has stopped |
| badOp | output | 1 | Stop caused by an unsupported opcode |
| divZero | output | 1 | Stop caused by a zero divisor |

## Verification
The assertions assume that `memRdData` reflects `memAddr` without delay and that reset is applied before any program runs. The bench meets both assumptions with a combinational model memory and a reset pulse before every program. The stall and fault properties also assume that memory never changes behind the core's back. The bench loads memory only while reset is held. Sweep operands avoid the single signed-divide overflow pair, so the bench's arithmetic model stays well defined.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DATA_W = 32;

  localparam logic [5:0] OP_ADD  = 6'd1;
  localparam logic [5:0] OP_DIV  = 6'd4;
  localparam logic [5:0] OP_MOD  = 6'd8;
  localparam logic [5:0] OP_SHR  = 6'd16;
  localparam logic [5:0] OP_ADDI = 6'd17;
  localparam logic [5:0] OP_SHRI = 6'd25;
  localparam logic [5:0] OP_INC  = 6'd26;
  localparam logic [5:0] OP_DEC  = 6'd27;
  localparam logic [5:0] OP_LIT  = 6'd28;
  localparam logic [5:0] OP_NOT  = 6'd30;
  localparam logic [5:0] OP_PUSH = 6'd31;
  localparam logic [5:0] OP_GET  = 6'd32;
  localparam logic [5:0] OP_PUT  = 6'd33;
  localparam logic [5:0] OP_LD   = 6'd34;
  localparam logic [5:0] OP_ST   = 6'd35;
  localparam logic [5:0] OP_JMP  = 6'd41;
  localparam logic [5:0] OP_JT   = 6'd42;
  localparam logic [5:0] OP_JF   = 6'd43;
  localparam logic [5:0] OP_JLE  = 6'd49;

  typedef enum logic [2:0] {
    ASEL_PC, ASEL_PC1, ASEL_FPARG, ASEL_ARG, ASEL_FPB, ASEL_SP1
  } addrSel_e;

  typedef enum logic [1:0] {WSEL_AC, WSEL_RES, WSEL_PUSH} wrSel_e;

  typedef struct packed {
    logic     ldOp;
    logic     ldArg;
    logic     ldOpnd;
    logic     ldAc;
    logic     takeJump;
    logic     stepPc;
    logic     bumpSp;
    logic     wrEn;
    addrSel_e addrSel;
    wrSel_e   wrSel;
  } ctrl_t;
endpackage

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int FP_INIT = 512,
  parameter int SP_INIT = 768
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic [DATA_W-1:0]   memRdData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [5:0]          opCode,
  output logic                acZero,
  output logic                leTaken,
  output logic                rhsZero
);
  localparam logic [ADDR_W-1:0] FP_BASE = ADDR_W'(FP_INIT);
  localparam logic [ADDR_W-1:0] SP_BASE = ADDR_W'(SP_INIT);

  logic [ADDR_W-1:0] pc, sp;
  logic [DATA_W-1:0] ac, opReg, argReg, opnd, rhs, res;
  logic [ADDR_W-1:0] jumpTarget;
  logic              useImm;

  assign opCode = (opReg[DATA_W-1:6] == '0) ? opReg[5:0] : 6'd0;
  assign useImm = (opCode >= OP_ADDI) && (opCode <= OP_SHRI);
  assign rhs    = useImm ? argReg : opnd;
  assign acZero = (ac == '0);
  assign rhsZero = (rhs == '0);
  assign leTaken = ($signed(ac) <= $signed(opnd));
  assign jumpTarget = (opCode == OP_JLE) ? argReg[8 +: ADDR_W] : argReg[ADDR_W-1:0];

  always_comb begin
    unique case (ctrl.addrSel)
      ASEL_PC:    memAddr = pc;
      ASEL_PC1:   memAddr = pc + 1'b1;
      ASEL_FPARG: memAddr = FP_BASE + argReg[ADDR_W-1:0];
      ASEL_ARG:   memAddr = argReg[ADDR_W-1:0];
      ASEL_FPB:   memAddr = FP_BASE + ADDR_W'(argReg[7:0]);
      ASEL_SP1:   memAddr = sp + 1'b1;
      default:    memAddr = pc;
    endcase
  end

  always_comb begin
    unique case (ctrl.wrSel)
      WSEL_RES:  memWrData = res;
      WSEL_PUSH: memWrData = (argReg == '0) ? ac : opnd;
      default:   memWrData = ac;
    endcase
  end

  always_comb begin
    res = ac;
    case (opCode)
      6'd1, 6'd17:  res = ac + rhs;
      6'd2, 6'd18:  res = ac - rhs;
      6'd3:         res = ac * rhs;
      6'd4:         res = rhsZero ? ac : DATA_W'($signed(ac) / $signed(rhs));
      6'd5, 6'd19:  res = ac & rhs;
      6'd6, 6'd20:  res = ac | rhs;
      6'd7:         res = ac ^ rhs;
      6'd8:         res = rhsZero ? ac : DATA_W'($signed(ac) % $signed(rhs));
      6'd9, 6'd21:  res = DATA_W'(ac == rhs);
      6'd10:        res = DATA_W'(ac != rhs);
      6'd11, 6'd22: res = DATA_W'($signed(ac) < $signed(rhs));
      6'd12, 6'd23: res = DATA_W'($signed(ac) <= $signed(rhs));
      6'd13:        res = DATA_W'($signed(ac) > $signed(rhs));
      6'd14:        res = DATA_W'($signed(ac) >= $signed(rhs));
      6'd15, 6'd24: res = ac << rhs[4:0];
      6'd16, 6'd25: res = ac >> rhs[4:0];
      OP_INC:       res = opnd + 1'b1;
      OP_DEC:       res = opnd - 1'b1;
      OP_LIT:       res = argReg;
      OP_NOT:       res = DATA_W'(acZero);
      OP_GET, OP_LD: res = opnd;
      default:      res = ac;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      sp     <= SP_BASE;
      ac     <= '0;
      opReg  <= '0;
      argReg <= '0;
      opnd   <= '0;
    end else begin
      if (ctrl.ldOp)     opReg  <= memRdData;
      if (ctrl.ldArg)    argReg <= memRdData;
      if (ctrl.ldOpnd)   opnd   <= memRdData;
      if (ctrl.ldAc)     ac     <= res;
      if (ctrl.bumpSp)   sp     <= sp + 1'b1;
      if (ctrl.takeJump) pc     <= jumpTarget;
      else if (ctrl.stepPc) pc  <= pc + 2'd2;
    end
  end
endmodule

// File: rtl/acc_control.sv
module acc_control
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] opCode,
  input  logic       acZero,
  input  logic       leTaken,
  input  logic       rhsZero,
  output ctrl_t      ctrl,
  output logic       halted,
  output logic       badOp,
  output logic       divZero
);
  typedef enum logic [2:0] {S_FOP, S_FARG, S_READ, S_EXEC, S_HALT} state_e;
  state_e state, stateNext;
  logic   setBad, setDiv, supported, isDivMod;

  assign supported = (opCode >= OP_ADD && opCode <= OP_LIT) ||
                     (opCode >= OP_NOT && opCode <= OP_ST) ||
                     (opCode >= OP_JMP && opCode <= OP_JF) ||
                     (opCode == OP_JLE);
  assign isDivMod = (opCode == OP_DIV) || (opCode == OP_MOD);

  always_comb begin
    ctrl      = '0;
    ctrl.addrSel = ASEL_PC;
    ctrl.wrSel   = WSEL_AC;
    stateNext = state;
    setBad    = 1'b0;
    setDiv    = 1'b0;
    unique case (state)
      S_FOP: begin
        ctrl.ldOp = 1'b1;
        stateNext = S_FARG;
      end
      S_FARG: begin
        ctrl.addrSel = ASEL_PC1;
        ctrl.ldArg   = 1'b1;
        if (supported) stateNext = S_READ;
        else begin
          stateNext = S_HALT;
          setBad    = 1'b1;
        end
      end
      S_READ: begin
        ctrl.ldOpnd  = 1'b1;
        ctrl.addrSel = (opCode == OP_LD)  ? ASEL_ARG :
                       (opCode == OP_JLE) ? ASEL_FPB : ASEL_FPARG;
        stateNext = S_EXEC;
      end
      S_EXEC: begin
        if (isDivMod && rhsZero) begin
          stateNext = S_HALT;
          setDiv    = 1'b1;
        end else begin
          stateNext   = S_FOP;
          ctrl.ldAc   = (opCode <= OP_LIT) || (opCode == OP_NOT) ||
                        (opCode == OP_GET) || (opCode == OP_LD);
          ctrl.takeJump = (opCode == OP_JMP) ||
                          (opCode == OP_JT  && !acZero) ||
                          (opCode == OP_JF  && acZero) ||
                          (opCode == OP_JLE && leTaken);
          ctrl.stepPc = 1'b1;
          case (opCode)
            OP_ST:  begin ctrl.wrEn = 1'b1; ctrl.addrSel = ASEL_ARG; end
            OP_PUT: begin ctrl.wrEn = 1'b1; ctrl.addrSel = ASEL_FPARG; end
            OP_INC, OP_DEC: begin
              ctrl.wrEn = 1'b1; ctrl.addrSel = ASEL_FPARG; ctrl.wrSel = WSEL_RES;
            end
            OP_PUSH: begin
              ctrl.wrEn = 1'b1; ctrl.addrSel = ASEL_SP1;
              ctrl.wrSel = WSEL_PUSH; ctrl.bumpSp = 1'b1;
            end
            default: ;
          endcase
        end
      end
      default: stateNext = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_FOP;
      badOp   <= 1'b0;
      divZero <= 1'b0;
    end else begin
      state <= stateNext;
      if (setBad) badOp   <= 1'b1;
      if (setDiv) divZero <= 1'b1;
    end
  end

  assign halted = (state == S_HALT);
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int FP_INIT = 512,
  parameter int SP_INIT = 768
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [31:0]       memRdData,
  output logic              memWrEn,
  output logic [31:0]       memWrData,
  output logic              halted,
  output logic              badOp,
  output logic              divZero
);
  ctrl_t      ctrl;
  logic [5:0] opCode;
  logic       acZero, leTaken, rhsZero;

  acc_datapath #(.ADDR_W(ADDR_W), .FP_INIT(FP_INIT), .SP_INIT(SP_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .opCode(opCode),
    .acZero(acZero), .leTaken(leTaken), .rhsZero(rhsZero)
  );

  acc_control u_ctl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .acZero(acZero),
    .leTaken(leTaken), .rhsZero(rhsZero), .ctrl(ctrl),
    .halted(halted), .badOp(badOp), .divZero(divZero)
  );

  assign memWrEn = ctrl.wrEn;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk (
  input logic clk,
  input logic rstN,
  input logic memWrEn,
  input logic halted,
  input logic badOp,
  input logic divZero
);
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted); // R12
  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memWrEn); // R12
  AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (badOp || divZero) |-> halted); // R11
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !(badOp && divZero)); // R11
  AST_DIVZERO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    divZero |=> divZero); // R11
  AST_WRITE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn); // R2
endmodule

bind acc_core acc_core_chk u_chk (
  .clk(clk), .rstN(rstN), .memWrEn(memWrEn),
  .halted(halted), .badOp(badOp), .divZero(divZero)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;
  localparam int AW = 10;
  localparam int FP = 512;
  localparam int SP = 768;
  localparam logic [31:0] FILL = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] memAddr;
  logic [31:0] memRdData, memWrData;
  logic memWrEn, halted, badOp, divZero;
  logic [31:0] mem [0:(1<<AW)-1];
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int runCyc;

  always #2 clk = ~clk;

  acc_core #(.ADDR_W(AW), .FP_INIT(FP), .SP_INIT(SP)) u_dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .halted(halted),
    .badOp(badOp), .divZero(divZero)
  );

  assign memRdData = mem[memAddr];
  always @(posedge clk) if (memWrEn) mem[memAddr] <= memWrData;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beginProg();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < (1 << AW); i++) mem[i] = FILL;
  endtask

  task automatic ins(input int at, input logic [31:0] op, input logic [31:0] arg);
    mem[at] = op;
    mem[at+1] = arg;
  endtask

  task automatic go();
    rstN = 1'b1;
    runCyc = 0;
    while (!halted && runCyc < 400) begin
      @(negedge clk);
      runCyc++;
    end
    if (!halted) chk("R2 timeout", 32'(runCyc), 32'd0);
  endtask

  function automatic logic [31:0] model(input int base, input logic [31:0] a, input logic [31:0] b);
    case (base)
      1: return a + b;
      2: return a - b;
      3: return a * b;
      4: return 32'($signed(a) / $signed(b));
      5: return a & b;
      6: return a | b;
      7: return a ^ b;
      8: return 32'($signed(a) % $signed(b));
      9: return 32'(a == b);
      10: return 32'(a != b);
      11: return 32'($signed(a) < $signed(b));
      12: return 32'($signed(a) <= $signed(b));
      13: return 32'($signed(a) > $signed(b));
      14: return 32'($signed(a) >= $signed(b));
      15: return a << b[4:0];
      default: return a >> b[4:0];
    endcase
  endfunction

  function automatic int immBase(input int op);
    case (op)
      17: return 1;  18: return 2;  19: return 5;  20: return 6;
      21: return 9;  22: return 11; 23: return 12; 24: return 15;
      default: return 16;
    endcase
  endfunction

  logic [31:0] va [6] = '{32'd5, 32'hFFFF_FFF9, 32'h8000_0000, 32'd3, 32'h0000_0F0F, 32'd100};
  logic [31:0] vb [6] = '{32'd3, 32'd2, 32'd1, 32'hFFFF_FFF7, 32'h0000_00FF, 32'd33};
  int badList [14] = '{0, 29, 36, 37, 38, 39, 40, 44, 45, 46, 47, 48, 50, 63};

  initial begin
    // R1: reset state
    beginProg();
    chk("R1 halted", {31'd0, halted}, 32'd0);
    chk("R1 badOp", {31'd0, badOp}, 32'd0);
    chk("R1 divZero", {31'd0, divZero}, 32'd0);
    chk("R1 memWrEn", {31'd0, memWrEn}, 32'd0);
    chk("R1 memAddr", 32'(memAddr), 32'd0);

    // R3: operand-from-frame sweep
    for (int op = 1; op <= 16; op++) begin
      for (int k = 0; k < 6; k++) begin
        beginProg();
        mem[FP+4] = vb[k];
        ins(0, 28, va[k]);
        ins(2, op, 4);
        ins(4, 35, 900);
        ins(6, 0, 0);
        go();
        chk($sformatf("R3 op%0d", op), mem[900], model(op, va[k], vb[k]));
        chk("R2 cycles", 32'(runCyc), 32'd14);
      end
    end

    // R4: immediate sweep
    for (int op = 17; op <= 25; op++) begin
      for (int k = 0; k < 6; k++) begin
        beginProg();
        ins(0, 28, va[k]);
        ins(2, op, vb[k]);
        ins(4, 35, 900);
        ins(6, 0, 0);
        go();
        chk($sformatf("R4 op%0d", op), mem[900], model(immBase(op), va[k], vb[k]));
      end
    end

    // R5: data movement
    beginProg();
    mem[FP+2] = 32'd77;
    ins(0, 32, 2);
    ins(2, 35, 901);
    ins(4, 28, 55);
    ins(6, 33, 3);
    ins(8, 34, 901);
    ins(10, 35, 902);
    ins(12, 0, 0);
    go();
    chk("R5 get/st", mem[901], 32'd77);
    chk("R5 put", mem[FP+3], 32'd55);
    chk("R5 ld", mem[902], 32'd77);

    // R6: jt, jf, jmp
    beginProg();
    ins(0, 28, 0);
    ins(2, 42, 12);
    ins(4, 43, 8);
    ins(6, 28, 111);
    ins(8, 28, 5);
    ins(10, 42, 16);
    ins(12, 28, 222);
    ins(14, 0, 0);
    ins(16, 35, 903);
    ins(18, 41, 22);
    ins(20, 28, 333);
    ins(22, 0, 0);
    go();
    chk("R6 branch path", mem[903], 32'd5);
    chk("R6 cycles", 32'(runCyc), 32'd30);
    chk("R6 no badOp at wrong path", {31'd0, badOp}, 32'd1);

    // R7 R8: counted loop with jle, target in bits 31:8
    beginProg();
    mem[FP+1] = 32'd0;
    mem[FP+2] = 32'd4;
    ins(0, 28, 0);
    ins(2, 26, 1);
    ins(4, 49, (32'd2 << 8) | 32'd2);
    ins(6, 35, 904);
    ins(8, 0, 0);
    go();
    chk("R7 loop exit value", mem[904], 32'd5);
    chk("R8 inc writeback", mem[FP+1], 32'd5);
    chk("R7 cycles", 32'(runCyc), 32'd4 * 12 + 2);

    // R8: dec below zero
    beginProg();
    mem[FP+1] = 32'd0;
    ins(0, 27, 1);
    ins(2, 35, 905);
    ins(4, 0, 0);
    go();
    chk("R8 dec AC", mem[905], 32'hFFFF_FFFF);
    chk("R8 dec writeback", mem[FP+1], 32'hFFFF_FFFF);

    // R9: push
    beginProg();
    mem[FP+3] = 32'd17;
    ins(0, 28, 42);
    ins(2, 31, 0);
    ins(4, 31, 3);
    ins(6, 0, 0);
    go();
    chk("R9 push AC", mem[SP+1], 32'd42);
    chk("R9 push local", mem[SP+2], 32'd17);
    chk("R9 slot untouched", mem[SP], FILL);

    // R10: not
    beginProg();
    ins(0, 28, 0);
    ins(2, 30, 0);
    ins(4, 35, 906);
    ins(6, 28, 9);
    ins(8, 30, 0);
    ins(10, 35, 907);
    ins(12, 0, 0);
    go();
    chk("R10 not zero", mem[906], 32'd1);
    chk("R10 not nonzero", mem[907], 32'd0);

    // R11: divide and remainder by zero
    for (int op = 4; op <= 8; op += 4) begin
      beginProg();
      mem[FP+4] = 32'd0;
      ins(0, 28, 9);
      ins(2, op, 4);
      ins(4, 35, 908);
      ins(6, 0, 0);
      go();
      chk("R11 divZero", {31'd0, divZero}, 32'd1);
      chk("R11 badOp low", {31'd0, badOp}, 32'd0);
      chk("R11 stop cycle", 32'(runCyc), 32'd8);
      chk("R11 no write", mem[908], FILL);
    end

    // R12: unsupported opcodes
    for (int k = 0; k < 14; k++) begin
      beginProg();
      ins(0, 28, 1);
      ins(2, badList[k], 909);
      ins(4, 35, 909);
      ins(6, 35, 910);
      go();
      repeat (6) @(negedge clk);
      chk($sformatf("R12 badOp op%0d", badList[k]), {31'd0, badOp}, 32'd1);
      chk("R12 halted held", {31'd0, halted}, 32'd1);
      chk("R2 stop cycle", 32'(runCyc), 32'd6);
      chk("R12 no write", mem[909], FILL);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule